// File: doc/BRIEF.md
# DRAM ECC Error Logging Unit

This unit sits beside the ECC checker of a two-channel DRAM controller and records what the checker finds. Single-cycle pulses mark a correctable or an uncorrectable error. Each pulse comes with the 33-bit physical address of the failing access, the channel that served it, the 8-bit syndrome and a destination code that tells what kind of access failed. Other single-cycle pulses mark a refresh timeout, a lock error outside DRAM and a thermal sensor event.

The unit keeps a status word of sticky flags and one captured error record. The record holds the cache-line pointer with the channel in bit 0, an extension bit that carries physical address bit 32, the syndrome and the destination code. An uncorrectable error has priority over a correctable one when the record is written. Three enable words turn selected status flags into three level outputs: a system-error line, a management interrupt and a control interrupt. Software reads all registers and writes the enables through a flat register port. Software clears flags by writing ones to them.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads 0 and all three reporting outputs are low.
- R2: A correctable pulse (ce_evt_i without ue_evt_i) while status bits 1:0 are both clear sets status bit 0 and captures four values. Register 1 gets {addr[31:7], 6'b0, chan}. Register 2 bit 0 gets addr[32]. Register 3 gets the syndrome. Register 4 gets the destination code, where 0 marks a processor memory read.
- R3: An uncorrectable pulse while status bit 1 is clear sets status bit 1 and writes the whole error record from its own inputs. This holds even when a correctable error is already logged. When both pulses arrive in the same cycle, both flags are set.
- R4: A correctable pulse while status bit 0 or bit 1 is already set leaves registers 1 to 4 unchanged and keeps status bit 0 set.
- R5: An uncorrectable pulse while status bit 1 is already set leaves registers 1 to 4 unchanged, so the first uncorrectable error is kept.
- R6: A write to register 0 clears each flag whose data bit is 1 and leaves flags with data bit 0 unchanged. Writes to registers 1 to 4 have no effect.
- R7: If an event pulse and a write-one-to-clear of the same flag fall in the same cycle, the flag stays set.
- R8: A refresh-timeout pulse sets status bit 8, a lock-error pulse sets bit 9 and a thermal pulse sets bit 11. None of them changes the error record.
- R9: Register 5 (system-error enables) holds written bits 0, 1, 8, 9 and 11. Register 6 (management enables) and register 7 (control enables) hold only bits 1:0. All other bits of these registers read 0.
- R10: Each reporting output is high exactly when (status AND its enable register) is non-zero: sys_err_o uses register 5, mgmt_irq_o uses register 6 and ctrl_irq_o uses register 7.
- R11: Unused status bits, pointer bits 6:1, extension bits 7:1 and all read data above each register's width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_evt_i | input | 1 | Correctable error pulse |
| ue_evt_i | input | 1 | Uncorrectable error pulse |
| err_addr_i | input | 33 | Physical address of the failing access |
| err_chan_i | input | 1 | Channel of the failing access |
| err_syn_i | input | 8 | ECC syndrome |
| err_dst_i | input | 8 | Destination code of the failing access |
| rfsh_to_i | input | 1 | Refresh timeout pulse |
| lock_err_i | input | 1 | Non-DRAM lock error pulse |
| therm_evt_i | input | 1 | Thermal sensor event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 status, 1 pointer, 2 extension, 3 syndrome, 4 destination, 5 to 7 enables) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the indexed register, combinational |
| sys_err_o | output | 1 | System error level |
| mgmt_irq_o | output | 1 | Management interrupt level |
| ctrl_irq_o | output | 1 | Control interrupt level |

## Verification
Two kinds of collision can land on the same edge. The first is a new event against software clearing that same flag. The bench drives a correctable pulse and a status write with bit 0 set in one cycle, and then expects the flag to read back as set. The second is a correctable and an uncorrectable pulse in one cycle, or an uncorrectable error arriving after a correctable one. Here the bench reads the record back and judges it by its syndrome and pointer: the uncorrectable error's values must win, and later correctable pulses must not disturb them.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int unsigned STS_W = 16;

  typedef enum logic [2:0] {
    RIDX_STS     = 3'd0,
    RIDX_PTR     = 3'd1,
    RIDX_EXT     = 3'd2,
    RIDX_SYN     = 3'd3,
    RIDX_DST     = 3'd4,
    RIDX_EN_SYS  = 3'd5,
    RIDX_EN_MGMT = 3'd6,
    RIDX_EN_CTRL = 3'd7
  } reg_idx_e;

  localparam int unsigned BIT_CE    = 0;
  localparam int unsigned BIT_UE    = 1;
  localparam int unsigned BIT_RFSH  = 8;
  localparam int unsigned BIT_LOCK  = 9;
  localparam int unsigned BIT_THERM = 11;

  localparam logic [STS_W-1:0] STS_MASK = 16'h0B03;
  localparam logic [STS_W-1:0] ECC_MASK = 16'h0003;
endpackage

// File: rtl/ecc_status_reg.sv
module ecc_status_reg
  import ecc_err_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o
);
  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    if (STS_MASK[b]) begin : g_flag
      logic flag_q;
      // set wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= set_i[b] | (flag_q & ~clr_i[b]);
      end
      assign sts_o[b] = flag_q;
    end else begin : g_tie
      assign sts_o[b] = 1'b0;
    end
  end

  logic unused_in;
  assign unused_in = ^(set_i & ~STS_MASK) ^ ^(clr_i & ~STS_MASK);
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned LINE_W = 7,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned DST_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_evt_i,
  input  logic             ue_evt_i,
  input  logic             ce_held_i,
  input  logic             ue_held_i,
  input  logic [PTR_W:0]   addr_i,
  input  logic             chan_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic [DST_W-1:0] dst_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ext_o,
  output logic [SYN_W-1:0] syn_o,
  output logic [DST_W-1:0] dst_o
);
  localparam int unsigned PAD_W = LINE_W - 1;

  logic             load_ue, load_ce, load;
  logic [PTR_W-1:0] ptr_d;

  // UE overwrites a logged CE; CE only lands in an empty log
  assign load_ue = ue_evt_i & ~ue_held_i;
  assign load_ce = ce_evt_i & ~ue_evt_i & ~ce_held_i & ~ue_held_i;
  assign load    = load_ue | load_ce;
  assign ptr_d   = {addr_i[PTR_W-1:LINE_W], {PAD_W{1'b0}}, chan_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      ext_o <= 1'b0;
      syn_o <= '0;
      dst_o <= '0;
    end else if (load) begin
      ptr_o <= ptr_d;
      ext_o <= addr_i[PTR_W];
      syn_o <= syn_i;
      dst_o <= dst_i;
    end
  end

  logic unused_line;
  assign unused_line = ^addr_i[LINE_W-1:0];
endmodule

// File: rtl/ecc_report.sv
module ecc_report
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned NUM_PATHS = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PATHS-1:0]            wr_i,
  input  logic [STS_W-1:0]                wdata_i,
  input  logic [STS_W-1:0]                sts_i,
  output logic [NUM_PATHS-1:0][STS_W-1:0] en_o,
  output logic [NUM_PATHS-1:0]            irq_o
);
  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    // path 0 covers every status source, the rest only ECC flags
    localparam logic [STS_W-1:0] MASK = (g == 0) ? STS_MASK : ECC_MASK;
    logic [STS_W-1:0] en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q <= '0;
      else if (wr_i[g]) en_q <= wdata_i & MASK;
    end

    assign en_o[g]  = en_q;
    assign irq_o[g] = |(sts_i & en_q);
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned LINE_W = 7,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned DST_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_evt_i,
  input  logic              ue_evt_i,
  input  logic [PTR_W:0]    err_addr_i,
  input  logic              err_chan_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic [DST_W-1:0]  err_dst_i,
  input  logic              rfsh_to_i,
  input  logic              lock_err_i,
  input  logic              therm_evt_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_err_o,
  output logic              mgmt_irq_o,
  output logic              ctrl_irq_o
);
  localparam int unsigned NUM_PATHS = 3;
  localparam int unsigned EN_BASE   = int'(RIDX_EN_SYS);

  logic [STS_W-1:0]                sts_set, sts_clr, sts_q;
  logic [PTR_W-1:0]                cap_ptr;
  logic                            cap_ext;
  logic [SYN_W-1:0]                cap_syn;
  logic [DST_W-1:0]                cap_dst;
  logic [NUM_PATHS-1:0]            en_wr;
  logic [NUM_PATHS-1:0][STS_W-1:0] en_q;
  logic [NUM_PATHS-1:0]            irq;

  always_comb begin
    sts_set            = '0;
    sts_set[BIT_CE]    = ce_evt_i;
    sts_set[BIT_UE]    = ue_evt_i;
    sts_set[BIT_RFSH]  = rfsh_to_i;
    sts_set[BIT_LOCK]  = lock_err_i;
    sts_set[BIT_THERM] = therm_evt_i;
  end

  assign sts_clr = (reg_wr_i && reg_addr_i == RIDX_STS) ? reg_wdata_i[STS_W-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NUM_PATHS; i++) begin
      en_wr[i] = reg_wr_i && (reg_addr_i == 3'(EN_BASE + i));
    end
  end

  ecc_status_reg i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr),
    .sts_o  (sts_q)
  );

  ecc_capture #(
    .PTR_W  (PTR_W),
    .LINE_W (LINE_W),
    .SYN_W  (SYN_W),
    .DST_W  (DST_W)
  ) i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_evt_i  (ce_evt_i),
    .ue_evt_i  (ue_evt_i),
    .ce_held_i (sts_q[BIT_CE]),
    .ue_held_i (sts_q[BIT_UE]),
    .addr_i    (err_addr_i),
    .chan_i    (err_chan_i),
    .syn_i     (err_syn_i),
    .dst_i     (err_dst_i),
    .ptr_o     (cap_ptr),
    .ext_o     (cap_ext),
    .syn_o     (cap_syn),
    .dst_o     (cap_dst)
  );

  ecc_report #(
    .NUM_PATHS (NUM_PATHS)
  ) i_report (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (en_wr),
    .wdata_i (reg_wdata_i[STS_W-1:0]),
    .sts_i   (sts_q),
    .en_o    (en_q),
    .irq_o   (irq)
  );

  assign sys_err_o  = irq[0];
  assign mgmt_irq_o = irq[1];
  assign ctrl_irq_o = irq[2];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_idx_e'(reg_addr_i))
      RIDX_STS:     reg_rdata_o[STS_W-1:0] = sts_q;
      RIDX_PTR:     reg_rdata_o[PTR_W-1:0] = cap_ptr;
      RIDX_EXT:     reg_rdata_o[0]         = cap_ext;
      RIDX_SYN:     reg_rdata_o[SYN_W-1:0] = cap_syn;
      RIDX_DST:     reg_rdata_o[DST_W-1:0] = cap_dst;
      RIDX_EN_SYS:  reg_rdata_o[STS_W-1:0] = en_q[0];
      RIDX_EN_MGMT: reg_rdata_o[STS_W-1:0] = en_q[1];
      RIDX_EN_CTRL: reg_rdata_o[STS_W-1:0] = en_q[2];
      default:      reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:STS_W];
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned LINE_W = 7,
  parameter int unsigned SYN_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ce_evt_i,
  input logic                    ue_evt_i,
  input logic [PTR_W-1:LINE_W]   line_i,
  input logic                    chan_i,
  input logic [SYN_W-1:0]        syn_i,
  input logic                    sts_wr_i,
  input logic [1:0]              clr_i,
  input logic [1:0]              flags_i,
  input logic                    any_sts_i,
  input logic [PTR_W-1:0]        ptr_i,
  input logic [SYN_W-1:0]        cap_syn_i,
  input logic                    sys_err_i,
  input logic                    mgmt_irq_i,
  input logic                    ctrl_irq_i
);
  a_r2_ce_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_evt_i && !ue_evt_i && flags_i == 2'b00)
      |=> (ptr_i[PTR_W-1:LINE_W] == $past(line_i) && ptr_i[0] == $past(chan_i)
           && cap_syn_i == $past(syn_i)));

  a_r3_ue_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_evt_i && !flags_i[1]) |=> (cap_syn_i == $past(syn_i) && flags_i[1]));

  a_r4_ce_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_evt_i && !ue_evt_i && flags_i != 2'b00) |=> ($stable(ptr_i) && $stable(cap_syn_i)));

  a_r5_ue_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_evt_i && flags_i[1]) |=> ($stable(ptr_i) && $stable(cap_syn_i)));

  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && clr_i[0] && !ce_evt_i) |=> !flags_i[0]);

  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_evt_i |=> flags_i[0]);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_sts_i |-> (!sys_err_i && !mgmt_irq_i && !ctrl_irq_i));
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .PTR_W  (PTR_W),
  .LINE_W (LINE_W),
  .SYN_W  (SYN_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_evt_i   (ce_evt_i),
  .ue_evt_i   (ue_evt_i),
  .line_i     (err_addr_i[PTR_W-1:LINE_W]),
  .chan_i     (err_chan_i),
  .syn_i      (err_syn_i),
  .sts_wr_i   (reg_wr_i && reg_addr_i == 3'd0),
  .clr_i      (reg_wdata_i[1:0]),
  .flags_i    (sts_q[1:0]),
  .any_sts_i  (|sts_q),
  .ptr_i      (cap_ptr),
  .cap_syn_i  (cap_syn),
  .sys_err_i  (sys_err_o),
  .mgmt_irq_i (mgmt_irq_o),
  .ctrl_irq_i (ctrl_irq_o)
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_evt_i = 1'b0, ue_evt_i = 1'b0;
  logic [32:0] err_addr_i = '0;
  logic        err_chan_i = 1'b0;
  logic [7:0]  err_syn_i = '0, err_dst_i = '0;
  logic        rfsh_to_i = 1'b0, lock_err_i = 1'b0, therm_evt_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        sys_err_o, mgmt_irq_o, ctrl_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_err_log i_ecc_err_log (
    .clk_i, .rst_ni, .ce_evt_i, .ue_evt_i, .err_addr_i, .err_chan_i,
    .err_syn_i, .err_dst_i, .rfsh_to_i, .lock_err_i, .therm_evt_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .sys_err_o, .mgmt_irq_o, .ctrl_irq_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_addr_i = idx;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_out(input string tag, input logic s, input logic m, input logic c);
    #1;
    chk(tag, {29'b0, sys_err_o, mgmt_irq_o, ctrl_irq_o}, {29'b0, s, m, c});
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = idx; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic err(input logic ce, input logic ue, input logic [32:0] a,
                     input logic ch, input logic [7:0] s, input logic [7:0] dst);
    @(negedge clk_i);
    ce_evt_i = ce; ue_evt_i = ue; err_addr_i = a; err_chan_i = ch;
    err_syn_i = s; err_dst_i = dst;
    @(negedge clk_i);
    ce_evt_i = 1'b0; ue_evt_i = 1'b0; err_addr_i = '0; err_syn_i = '0; err_dst_i = '0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) chk_reg($sformatf("R1 reg %0d after reset", i), 3'(i), 32'h0);
    chk_out("R1 outputs after reset", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    err(1'b1, 1'b0, 33'h1_2345_67FF, 1'b1, 8'h5A, 8'h00);
    chk_reg("R2 status", 3'd0, 32'h1);
    chk_reg("R2 pointer", 3'd1, 32'h2345_6781);
    chk_reg("R2 extension", 3'd2, 32'h1);
    chk_reg("R2 syndrome", 3'd3, 32'h5A);
    chk_reg("R2 destination", 3'd4, 32'h0);
    err(1'b1, 1'b0, 33'h0_0000_1000, 1'b0, 8'h11, 8'h03);
    chk_reg("R4 pointer kept", 3'd1, 32'h2345_6781);
    chk_reg("R4 syndrome kept", 3'd3, 32'h5A);
    chk_reg("R4 status", 3'd0, 32'h1);
    err(1'b0, 1'b1, 33'h0_ABCD_EF80, 1'b0, 8'hC3, 8'h02);
    chk_reg("R3 status", 3'd0, 32'h3);
    chk_reg("R3 pointer", 3'd1, 32'hABCD_EF80);
    chk_reg("R3 extension", 3'd2, 32'h0);
    chk_reg("R3 syndrome", 3'd3, 32'hC3);
    chk_reg("R3 destination", 3'd4, 32'h2);
    err(1'b1, 1'b0, 33'h1_FFFF_FFFF, 1'b1, 8'h77, 8'h05);
    chk_reg("R4 ce after ue", 3'd3, 32'hC3);
    err(1'b0, 1'b1, 33'h1_1111_1100, 1'b1, 8'h99, 8'h06);
    chk_reg("R5 second ue pointer", 3'd1, 32'hABCD_EF80);
    chk_reg("R5 second ue syndrome", 3'd3, 32'hC3);
  endtask

  task automatic t_clear;
    wr(3'd0, 32'h0);
    chk_reg("R6 zero write keeps", 3'd0, 32'h3);
    wr(3'd0, 32'h1);
    chk_reg("R6 clear ce", 3'd0, 32'h2);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    chk_reg("R6 pointer read-only", 3'd1, 32'hABCD_EF80);
    chk_reg("R6 syndrome read-only", 3'd3, 32'hC3);
    wr(3'd0, 32'h2);
    chk_reg("R6 clear ue", 3'd0, 32'h0);
  endtask

  task automatic t_same_cycle;
    err(1'b1, 1'b1, 33'h0_0000_0280, 1'b1, 8'h3C, 8'h00);
    chk_reg("R3 both pulses status", 3'd0, 32'h3);
    chk_reg("R3 both pulses syndrome", 3'd3, 32'h3C);
    wr(3'd0, 32'h3);
    err(1'b1, 1'b0, 33'h0_0000_0400, 1'b0, 8'h21, 8'h00);
    @(negedge clk_i);
    ce_evt_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'h1;
    @(negedge clk_i);
    ce_evt_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    chk_reg("R7 event beats clear", 3'd0, 32'h1);
    wr(3'd0, 32'h1);
    chk_reg("R7 later clear", 3'd0, 32'h0);
  endtask

  task automatic t_other;
    @(negedge clk_i);
    rfsh_to_i = 1'b1; lock_err_i = 1'b1; therm_evt_i = 1'b1;
    @(negedge clk_i);
    rfsh_to_i = 1'b0; lock_err_i = 1'b0; therm_evt_i = 1'b0;
    chk_reg("R8 other flags", 3'd0, 32'h0B00);
    chk_reg("R8 record kept", 3'd3, 32'h21);
    wr(3'd0, 32'hFFFF_FFFF);
    chk_reg("R11 status cleared, no stray bits", 3'd0, 32'h0);
    err(1'b1, 1'b0, 33'h1_0000_00FF, 1'b0, 8'hFF, 8'hFF);
    chk_reg("R11 pointer low bits zero", 3'd1, 32'h0000_0080);
    chk_reg("R11 extension upper bits zero", 3'd2, 32'h1);
    wr(3'd0, 32'h1);
  endtask

  task automatic t_enables;
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    chk_reg("R9 system enables", 3'd5, 32'h0B03);
    chk_reg("R9 management enables", 3'd6, 32'h0003);
    chk_reg("R9 control enables", 3'd7, 32'h0003);
  endtask

  task automatic t_report;
    wr(3'd5, 32'h0800);
    wr(3'd6, 32'h0002);
    wr(3'd7, 32'h0001);
    chk_out("R10 idle", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i); therm_evt_i = 1'b1;
    @(negedge clk_i); therm_evt_i = 1'b0;
    chk_out("R10 thermal to system", 1'b1, 1'b0, 1'b0);
    wr(3'd0, 32'h0800);
    chk_out("R10 drop after clear", 1'b0, 1'b0, 1'b0);
    err(1'b1, 1'b0, 33'h0_0000_1000, 1'b0, 8'h01, 8'h00);
    chk_out("R10 ce to control", 1'b0, 1'b0, 1'b1);
    err(1'b0, 1'b1, 33'h0_0000_2000, 1'b0, 8'h02, 8'h00);
    chk_out("R10 ue to management", 1'b0, 1'b1, 1'b1);
    wr(3'd0, 32'h0003);
    chk_out("R10 all low", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_priority();
    t_clear();
    t_same_cycle();
    t_other();
    t_enables();
    t_report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule